// File: doc/BRIEF.md
# Byte-Lane Static RAM Functional Model

This block is a clock-sampled, synthesizable stand-in for a 16-bit-wide asynchronous static RAM with active-low chip select, write strobe and output strobe, plus one active-low enable per byte lane. On every rising clock edge it samples the control pins and classifies the access into one of four modes: standby, outputs off, read or write. A write stores only the byte lanes whose enables are low. A read presents stored data on the lanes whose enables are low. Each lane's driven state is reported on a separate flag, so no real tri-state net is needed.

The storage depth is set by `ADDR_W`. A full-size part uses `ADDR_W = 17`, which gives 131,072 words and 17 address inputs. The default build is smaller so that it elaborates cheaply. Each lane is kept in its own byte-wide array so that block RAM can be inferred, and read data is registered. An undriven lane is reported as a cleared flag with its data bits held at zero. Memory contents after power-up are undefined, and reset does not clear them.

Top module: `sram_lane_model`

## Requirements
- R1: While `rst` is high at a clock edge, both `lane_drv` bits and all `rdata` bits are 0 after that edge.
- R2: When `cs_n` is 1 at an edge, `lane_drv` becomes 2'b00 and the storage is left unchanged, whatever `wr_n`, `rd_n`, the lane enables, the address or the write data are.
- R3: When `cs_n` = 0, `wr_n` = 1 and `rd_n` = 1 at an edge, `lane_drv` becomes 2'b00.
- R4: When `cs_n` = 0, `wr_n` = 1 and `rd_n` = 0 at an edge, each lane whose enable is 0 is driven after that edge with the word stored at `addr`. A lane whose enable is 1 is not driven.
- R5: Lane 0 is governed by `lo_en_n`, maps to data bits 7:0 and is reported on `lane_drv[0]`. Lane 1 is governed by `hi_en_n`, maps to bits 15:8 and is reported on `lane_drv[1]`.
- R6: A write (`cs_n` = 0 and `wr_n` = 0) stores the `wdata` byte of each lane whose enable is 0. The other lane keeps its previous byte.
- R7: A write takes place whatever the value of `rd_n`, and `lane_drv` is 2'b00 after every edge that sampled a write.
- R8: Read data and lane flags take effect exactly one clock edge after the sampled access. A read in the cycle after a write returns the newly written bytes.
- R9: The `rdata` bits of any lane whose `lane_drv` bit is 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output flags |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output strobe, active low |
| lo_en_n | input | 1 | Lane 0 (bits 7:0) enable, active low |
| hi_en_n | input | 1 | Lane 1 (bits 15:8) enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Data to store |
| rdata | output | 16 | Read data, zero on undriven lanes |
| lane_drv | output | 2 | Per-lane driven flag (0 = high impedance) |

## Verification
Assertions check on every cycle how the sampled mode maps onto the lane flags: the flags are quiet after standby, outputs-off and write cycles, they follow the lane enables after a read, they are cleared after reset, and an undriven lane shows zero data. Whether storage keeps its bytes, that is whether a masked lane or a deselected write leaves memory untouched, and whether read data matches what was written, can only be shown by the bench's write-then-read sequences compared against its shadow memory.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_NO_OUT  = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

  // Classify the control pins of one access.
  function automatic sram_mode_e classify(input logic cs_n, input logic wr_n,
                                          input logic rd_n);
    sram_mode_e m;
    if (cs_n)       m = MODE_STANDBY;
    else if (!wr_n) m = MODE_WRITE;
    else if (!rd_n) m = MODE_READ;
    else            m = MODE_NO_OUT;
    return m;
  endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [LANES-1:0] be_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] wr_en
);

  always_comb mode = classify(cs_n, wr_n, rd_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      rd_en[g] = (mode == MODE_READ)  && !be_n[g];
      wr_en[g] = (mode == MODE_WRITE) && !be_n[g];
    end
  end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte,
  output logic              drv
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_q;

  // Storage: no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wbyte;
    if (rd_en) rd_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) drv <= 1'b0;
    else     drv <= rd_en;
  end

  always_comb rbyte = drv ? rd_q : '0;

  // A lane that was not driven must present zero data.
  assert_idle_lane_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !drv |-> (rbyte == '0));

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              lo_en_n,
  input  logic              hi_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lane_drv
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  sram_mode_e       mode;
  logic [LANES-1:0] rd_en;
  logic [LANES-1:0] wr_en;
  logic [LANES-1:0] be_n;

  always_comb be_n = {hi_en_n, lo_en_n};

  sram_mode_decode #(.LANES(LANES)) u_dec (
    .cs_n  (cs_n),
    .wr_n  (wr_n),
    .rd_n  (rd_n),
    .be_n  (be_n),
    .mode  (mode),
    .rd_en (rd_en),
    .wr_en (wr_en)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .rd_en (rd_en[g]),
      .wr_en (wr_en[g]),
      .addr  (addr),
      .wbyte (wdata[g*LANE_W +: LANE_W]),
      .rbyte (rdata[g*LANE_W +: LANE_W]),
      .drv   (lane_drv[g])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (lane_drv == 2'b00) && (rdata == '0));

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (lane_drv == 2'b00));

  assert_outputs_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_n && rd_n) |=> (lane_drv == 2'b00));

  assert_read_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_n && !rd_n) |=> (lane_drv == {!$past(hi_en_n), !$past(lo_en_n)}));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE) |=> (lane_drv == 2'b00));

endmodule

// File: tb/sim_sram_lane_model.sv
module sim_sram_lane_model;

  localparam int AW = 10;

  typedef struct {
    logic [1:0]  drv;
    logic [15:0] data;
    string       req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, lo_en_n = 1'b1, hi_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    lane_drv;

  item_t       sb_q[$];
  logic [15:0] shadow [int];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sram_lane_model #(.ADDR_W(AW), .DATA_W(16)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_drv(lane_drv)
  );

  // Driver: applies one access and pushes the expected outcome.
  task automatic apply(input logic r, input logic c, input logic w, input logic o,
                       input logic lo, input logic hi, input int a,
                       input logic [15:0] d, input string req);
    item_t it;
    logic [15:0] cur;
    @(negedge clk);
    rst = r; cs_n = c; wr_n = w; rd_n = o; lo_en_n = lo; hi_en_n = hi;
    addr = AW'(a); wdata = d;
    it.drv = 2'b00; it.data = 16'h0; it.req = req;
    cur = shadow.exists(a) ? shadow[a] : 16'h0;
    if (!r && !c && w && !o) begin
      it.drv = {!hi, !lo};
      it.data = {hi ? 8'h00 : cur[15:8], lo ? 8'h00 : cur[7:0]};
    end
    if (!r && !c && !w) begin
      if (!lo) cur[7:0]  = d[7:0];
      if (!hi) cur[15:8] = d[15:8];
      shadow[a] = cur;
    end
    sb_q.push_back(it);
  endtask

  // Monitor: one result per edge, compared away from the edge.
  initial begin
    item_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_vec++;
        if (lane_drv !== e.drv || rdata !== e.data) begin
          n_bad++;
          $display("FAIL %s: drv=%b data=%h expected drv=%b data=%h",
                   e.req, lane_drv, rdata, e.drv, e.data);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with a read request present
    apply(1, 0, 1, 0, 0, 0, 5, 16'h0, "R1");
    apply(1, 1, 1, 1, 1, 1, 0, 16'h0, "R1");
    // R7: full writes, with output strobe high and low
    apply(0, 0, 0, 1, 0, 0, 5, 16'hA5C3, "R7");
    apply(0, 0, 0, 0, 0, 0, 1023, 16'h1234, "R7");
    // R4 / R8: full read
    apply(0, 0, 1, 0, 0, 0, 5, 16'h0, "R4");
    // R5 / R9: single lanes
    apply(0, 0, 1, 0, 0, 1, 5, 16'h0, "R5_lo");
    apply(0, 0, 1, 0, 1, 0, 5, 16'h0, "R5_hi");
    apply(0, 0, 1, 0, 1, 1, 5, 16'h0, "R9");
    // R6: lane-masked writes, each followed by a read (R8)
    apply(0, 0, 0, 1, 0, 1, 5, 16'hFFEE, "R6_lo");
    apply(0, 0, 1, 0, 0, 0, 5, 16'h0, "R6");
    apply(0, 0, 0, 0, 1, 0, 5, 16'h7700, "R6_hi");
    apply(0, 0, 1, 0, 0, 0, 5, 16'h0, "R8");
    // R2: deselected write attempt, then read back
    apply(0, 1, 0, 0, 0, 0, 5, 16'h0000, "R2");
    apply(0, 1, 1, 0, 0, 0, 5, 16'h0, "R2");
    apply(0, 0, 1, 0, 0, 0, 5, 16'h0, "R2");
    // R3: outputs off
    apply(0, 0, 1, 1, 0, 0, 5, 16'h0, "R3");
    apply(0, 0, 1, 0, 0, 0, 1023, 16'h0, "R4");
    // R6: write with both enables high leaves the word unchanged
    apply(0, 0, 0, 0, 1, 1, 1023, 16'hBEEF, "R6");
    apply(0, 0, 1, 0, 0, 0, 1023, 16'h0, "R6");
    // R8: back-to-back writes and reads over several addresses
    for (int i = 0; i < 8; i++)
      apply(0, 0, 0, 1, 0, 0, 100 + i, 16'(16'h1111 * (i + 1)), "R8");
    for (int i = 0; i < 8; i++)
      apply(0, 0, 1, 0, i[0], !i[0], 100 + i, 16'h0, "R8");
    // R1: reset again, mid-run
    apply(1, 0, 1, 0, 0, 0, 5, 16'h0, "R1");
    apply(0, 0, 1, 0, 0, 0, 5, 16'h0, "R1");
    apply(0, 1, 1, 1, 1, 1, 0, 16'h0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule